// File: doc/BRIEF.md
# Card Host Interrupt Control and Status Register

This block is the interrupt control register of a card host controller. It keeps one sticky flag per interrupt source and, in the bit just below each flag, that source's enable. Event pulses from the controller datapath set the flags. One registered interrupt line is driven high while any flag is set together with its own enable. The same word also holds a few non-interrupt controls: a DMA enable, a polarity select, a word length field and a mode field.

Software reaches the word through three write offsets. A write to the base offset replaces the whole writable contents. A write to the set alias ORs the written mask in. A write to the clear alias removes exactly the bits of the written mask. Because of the aliases, software can acknowledge one flag or switch one enable without a read-modify-write. A fourth offset reads back a status word that shows the live card-detect and SDIO interrupt lines. All reads are combinational.

Top module: `hostirq_csr`

## Requirements
- R1: Writable bits are 31..14 except 19 and 18, plus 13, 9 and 7..0, so the writable mask is 0xFFF3E2FF. A write at byte offset 0x0 loads wr_data masked by this mask into the word. All other bits always read 0. Reads at offsets 0x0, 0x4 and 0x8 return the word.
- R2: A write at offset 0x4 sets the writable bits that are 1 in wr_data and leaves every other bit unchanged.
- R3: A write at offset 0x8 clears the writable bits that are 1 in wr_data and leaves every other bit unchanged.
- R4: Event input k sets its flag on the next clock edge whether or not its enable is set. Flag/enable bit pairs, for k = 0..7: SDIO 31/30, response error 29/28, response timeout 27/26, data timeout 25/24, data CRC 23/22, FIFO underrun 21/20, receive timeout 17/16, FIFO overrun 15/14.
- R5: An event pulse in the same cycle as a write that would clear its flag (clear alias, or a base load with that bit 0) leaves the flag set.
- R6: irq is registered. One cycle after the word holds some flag together with the bit below it, irq is 1, and otherwise it is 0.
- R7: A pending SDIO flag (bit 31) drives irq only while the SDIO enable (bit 30) is set. Setting bit 30 through the set alias raises irq one cycle later.
- R8: Reads at offset 0xC return a status word: bit 28 is the inverse of card_present (0 while a card is present), bit 17 follows sdio_line, and all other bits are 0. Writes to 0xC, and to any offset other than 0x0, 0x4 and 0x8, change nothing.
- R9: While rst is high, the word and irq are cleared to 0.
- R10: The control bits (13 DMA enable, 9 polarity, 7..4 word length, 3..0 mode) follow the same load, set and clear rules and are never changed by events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data or bit mask |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| evt_pulse | input | 8 | Event pulses, one per interrupt source |
| card_present | input | 1 | Live card presence line |
| sdio_line | input | 1 | Live SDIO interrupt line |
| irq | output | 1 | Registered interrupt request |

## Verification
A write or event sampled at a clock edge shows up in rd_data right after that edge. irq reflects the new word one edge later. Reads of the status offset follow the live lines in the same cycle. The bench drives inputs just after a rising edge and samples on the falling edge. A behavioural model applies each sampled write and event at the edge and keeps its own one-cycle-delayed interrupt value, so every comparison falls in the cycle where the result is due. Directed phases cover event-versus-clear collisions and the SDIO enable gating. A pseudo-random phase mixes all offsets and events.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
    localparam int REG_W  = 32;
    localparam int N_EVT  = 8;
    localparam int CTRL_W = 10;

    typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_SET, OP_CLR} wop_e;

    localparam logic [3:0] OFS_BASE = 4'h0;
    localparam logic [3:0] OFS_SET  = 4'h4;
    localparam logic [3:0] OFS_CLR  = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'hC;

    localparam int STAT_CD_BIT   = 28;
    localparam int STAT_SDIO_BIT = 17;
    localparam int BIT_DMA_EN    = 13;
    localparam int BIT_POL       = 9;

    typedef struct packed {
        logic       dma_en;
        logic       pol;
        logic [3:0] wlen;
        logic [3:0] mode;
    } ctrl_t;

    // flag position of event k; its enable sits one bit lower
    function automatic int flag_pos(input int k);
        case (k)
            0: return 31;
            1: return 29;
            2: return 27;
            3: return 25;
            4: return 23;
            5: return 21;
            6: return 17;
            default: return 15;
        endcase
    endfunction

    function automatic logic apply_bit(input wop_e op, input logic cur, input logic d);
        case (op)
            OP_LOAD: return d;
            OP_SET:  return cur | d;
            OP_CLR:  return cur & ~d;
            default: return cur;
        endcase
    endfunction

    function automatic logic [CTRL_W-1:0] apply_vec(input wop_e op,
                                                    input logic [CTRL_W-1:0] cur,
                                                    input logic [CTRL_W-1:0] d);
        case (op)
            OP_LOAD: return d;
            OP_SET:  return cur | d;
            OP_CLR:  return cur & ~d;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/hostirq_pair.sv
module hostirq_pair
    import hostirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  wop_e op,
    input  logic wd_flag,
    input  logic wd_en,
    input  logic evt,
    output logic flag_q,
    output logic en_q
);
    logic flag_d;

    always_comb begin
        flag_d = apply_bit(op, flag_q, wd_flag) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            flag_q <= flag_d;
            en_q   <= apply_bit(op, en_q, wd_en);
        end
    end
endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
    import hostirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wop_e              op,
    input  logic [CTRL_W-1:0] wd,
    output ctrl_t             ctrl_q
);
    logic [CTRL_W-1:0] nxt;

    always_comb begin
        nxt = apply_vec(op, ctrl_q, wd);
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= nxt;
    end
endmodule

// File: rtl/hostirq_reduce.sv
module hostirq_reduce
    import hostirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] flags,
    input  logic [N_EVT-1:0] enables,
    output logic             irq_q
);
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flags & enables);
    end
endmodule

// File: rtl/hostirq_csr.sv
module hostirq_csr
    import hostirq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [N_EVT-1:0]  evt_pulse,
    input  logic              card_present,
    input  logic              sdio_line,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFS_BASE);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    wop_e              op;
    logic [N_EVT-1:0]  flags;
    logic [N_EVT-1:0]  enables;
    ctrl_t             ctrl_q;
    logic [CTRL_W-1:0] ctrl_wd;
    logic [REG_W-1:0]  reg_word;
    logic [REG_W-1:0]  stat_word;
    logic              unused_wbits;

    always_comb begin
        op = OP_NONE;
        if (wr_en) begin
            if (wr_addr == A_BASE)      op = OP_LOAD;
            else if (wr_addr == A_SET)  op = OP_SET;
            else if (wr_addr == A_CLR)  op = OP_CLR;
        end
    end

    for (genvar k = 0; k < N_EVT; k++) begin : g_pair
        localparam int FP = flag_pos(k);
        hostirq_pair u_pair (
            .clk    (clk),
            .rst    (rst),
            .op     (op),
            .wd_flag(wr_data[FP]),
            .wd_en  (wr_data[FP-1]),
            .evt    (evt_pulse[k]),
            .flag_q (flags[k]),
            .en_q   (enables[k])
        );
    end

    assign ctrl_wd = {wr_data[BIT_DMA_EN], wr_data[BIT_POL], wr_data[7:0]};

    hostirq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wd    (ctrl_wd),
        .ctrl_q(ctrl_q)
    );

    hostirq_reduce u_reduce (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .enables(enables),
        .irq_q  (irq)
    );

    always_comb begin
        reg_word = '0;
        for (int k = 0; k < N_EVT; k++) begin
            reg_word[flag_pos(k)]     = flags[k];
            reg_word[flag_pos(k) - 1] = enables[k];
        end
        reg_word[BIT_DMA_EN] = ctrl_q.dma_en;
        reg_word[BIT_POL]    = ctrl_q.pol;
        reg_word[7:4]        = ctrl_q.wlen;
        reg_word[3:0]        = ctrl_q.mode;
    end

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_CD_BIT]   = ~card_present;
        stat_word[STAT_SDIO_BIT] = sdio_line;
    end

    always_comb begin
        if (rd_addr == A_BASE || rd_addr == A_SET || rd_addr == A_CLR) rd_data = reg_word;
        else if (rd_addr == A_STAT)                                    rd_data = stat_word;
        else                                                           rd_data = '0;
    end

    assign unused_wbits = ^{wr_data[19:18], wr_data[12:10], wr_data[8]};
endmodule

// File: rtl/hostirq_csr_chk.sv
module hostirq_csr_chk
    import hostirq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [REG_W-1:0]  rd_data,
    input logic [N_EVT-1:0]  evt_pulse,
    input logic              card_present,
    input logic              sdio_line,
    input logic              irq,
    input logic [REG_W-1:0]  reg_word
);
    localparam logic [REG_W-1:0] WMASK = 32'hFFF3_E2FF;
    localparam logic [REG_W-1:0] FMASK = 32'hAAA2_8000;

    // R1: bits outside the writable mask never hold a 1
    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_word & ~WMASK) == '0);

    // R3: clear alias without events removes every selected bit
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(OFS_CLR) && evt_pulse == '0)
        |=> (reg_word & $past(wr_data)) == '0);

    for (genvar k = 0; k < N_EVT; k++) begin : g_ev
        localparam int FP = flag_pos(k);
        // R4: an event always lands in its flag
        p_evt_sets_r4: assert property (@(posedge clk) disable iff (rst)
            evt_pulse[k] |=> reg_word[FP]);
        // R5: event beats a same-cycle clear of its flag
        p_evt_beats_clr_r5: assert property (@(posedge clk) disable iff (rst)
            (evt_pulse[k] && wr_en && wr_addr == ADDR_W'(OFS_CLR) && wr_data[FP])
            |=> reg_word[FP]);
    end

    // R6: irq is the word's enabled flags, one cycle late
    p_irq_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(|(reg_word & FMASK & (reg_word << 1))));

    // R8: status offset mirrors the live lines
    p_status_r8: assert property (@(posedge clk) disable iff (rst)
        rd_addr == ADDR_W'(OFS_STAT)
        |-> rd_data == ((32'(!card_present) << STAT_CD_BIT) | (32'(sdio_line) << STAT_SDIO_BIT)));

    // R9: reset clears word and interrupt
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (reg_word == '0 && !irq));
endmodule

bind hostirq_csr hostirq_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .evt_pulse   (evt_pulse),
    .card_present(card_present),
    .sdio_line   (sdio_line),
    .irq         (irq),
    .reg_word    (reg_word)
);

// File: tb/sim_hostirq_csr.sv
module sim_hostirq_csr;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam logic [31:0] WMASK = 32'hFFF3_E2FF;
    localparam logic [31:0] FMASK = 32'hAAA2_8000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [7:0]    evt_pulse = '0;
    logic          card_present = 1'b0;
    logic          sdio_line = 1'b0;
    logic          irq;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R9";
    logic [31:0] m_reg = '0;
    logic        m_irq = 1'b0;
    logic [31:0] nxt;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostirq_csr #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_pulse(evt_pulse),
        .card_present(card_present), .sdio_line(sdio_line), .irq(irq)
    );

    function automatic int fpos(input int k);
        int t[8] = '{31, 29, 27, 25, 23, 21, 17, 15};
        return t[k];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [7:0] e);
        wr_en = 1'b1; wr_addr = a; wr_data = d; evt_pulse = e;
        step();
        wr_en = 1'b0; evt_pulse = '0;
    endtask

    // reference model: applies sampled stimulus at each edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_reg <= '0;
            m_irq <= 1'b0;
        end else begin
            nxt = m_reg;
            if (wr_en) begin
                case (wr_addr)
                    4'h0: nxt = wr_data & WMASK;
                    4'h4: nxt = m_reg | (wr_data & WMASK);
                    4'h8: nxt = m_reg & ~(wr_data & WMASK);
                    default: ;
                endcase
            end
            for (int k = 0; k < 8; k++) if (evt_pulse[k]) nxt[fpos(k)] = 1'b1;
            m_irq <= |(m_reg & FMASK & (m_reg << 1));
            m_reg <= nxt;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] exp_rd;
            if (rd_addr == 4'h0 || rd_addr == 4'h4 || rd_addr == 4'h8) exp_rd = m_reg;
            else if (rd_addr == 4'hC) exp_rd = (32'(!card_present) << 28) | (32'(sdio_line) << 17);
            else exp_rd = '0;
            chk(cur_req, rd_data, exp_rd);
            chk("R6", {31'd0, irq}, {31'd0, m_irq});
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R9 reset state
        chk("R9", rd_data, 32'h0);
        chk("R9", {31'd0, irq}, 32'h0);

        // R1 load all ones: only writable bits stick
        cur_req = "R1";
        wr(4'h0, 32'hFFFF_FFFF, 8'h0);
        chk("R1", rd_data, WMASK);
        rd_addr = 4'h4; #1 chk("R1", rd_data, WMASK);
        rd_addr = 4'h0;
        wr(4'h0, 32'h0, 8'h0);
        step();

        // R2 set alias: enables and control bits
        cur_req = "R2";
        wr(4'h4, 32'h5550_0000, 8'h0);
        chk("R2", rd_data, 32'h5550_0000);
        cur_req = "R10";
        wr(4'h4, 32'h0000_22A5, 8'h0);
        chk("R10", rd_data, 32'h5550_22A5);
        wr(4'h8, 32'h0000_00F0, 8'h0);
        chk("R10", rd_data, 32'h5550_2205);
        wr(4'h0, 32'h0000_0000, 8'h0);
        step();

        // R4 each event latches with enables low, irq stays low
        cur_req = "R4";
        for (int k = 0; k < 8; k++) begin
            wr(4'h0, 32'h0, 8'h0);
            wr(4'h0, 32'h0, 8'(1 << k)); // load 0 plus event: R5 as well
            chk("R4", rd_data, 32'(1) << fpos(k));
            step();
            chk("R4", {31'd0, irq}, 32'h0);
        end
        wr(4'h4, 32'h0000_00A5, 8'hFF);
        chk("R10", rd_data, FMASK | 32'h0000_00A5);

        // R3 clear alias removes exactly the selected bits
        cur_req = "R3";
        wr(4'h8, 32'h2280_0000, 8'h0);
        chk("R3", rd_data, (FMASK & ~32'h2280_0000) | 32'h0000_00A5);

        // R5 event beats same-cycle clear
        cur_req = "R5";
        wr(4'h8, 32'hFFFF_FFFF, 8'h04);
        chk("R5", rd_data, 32'h0800_0000);
        wr(4'h0, 32'h0, 8'h0);

        // R7 SDIO flag gated by its enable
        cur_req = "R7";
        wr(4'h0, 32'h0, 8'h01);
        step(); step();
        chk("R7", {31'd0, irq}, 32'h0);
        wr(4'h4, 32'h4000_0000, 8'h0);
        chk("R7", {31'd0, irq}, 32'h0);
        step();
        chk("R7", {31'd0, irq}, 32'h1);
        wr(4'h8, 32'h8000_0000, 8'h0);
        step();
        chk("R7", {31'd0, irq}, 32'h0);

        // R8 status word, writes there ignored
        cur_req = "R8";
        rd_addr = 4'hC;
        card_present = 1'b1; sdio_line = 1'b0; #1
        chk("R8", rd_data, 32'h0);
        card_present = 1'b0; sdio_line = 1'b1; #1
        chk("R8", rd_data, 32'h1002_0000);
        wr(4'hC, 32'hFFFF_FFFF, 8'h0);
        rd_addr = 4'h0; #1
        chk("R8", rd_data, 32'h4000_0000);

        // mixed pseudo-random traffic
        cur_req = "R6";
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr_en = lfsr[3] & lfsr[7];
            case (lfsr[9:8])
                2'd0: wr_addr = 4'h0;
                2'd1: wr_addr = 4'h4;
                2'd2: wr_addr = 4'h8;
                default: wr_addr = lfsr[10] ? 4'hC : 4'h2;
            endcase
            wr_data = {lfsr[15:0], lfsr[31:16]} ^ 32'(i * 32'h9E37);
            evt_pulse = (lfsr[12] & lfsr[13]) ? lfsr[23:16] : 8'h0;
            rd_addr = lfsr[14] ? 4'hC : {lfsr[27:26], 2'b00};
            card_present = lfsr[5];
            sdio_line = lfsr[6];
            step();
        end
        wr_en = 1'b0; evt_pulse = '0;
        step(); step();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule